// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests for up to 32 priority slots. It picks the one pending request with the highest priority and presents the word address of its vector. The vector table sits at the very top of a 16-bit address space and ends at 0xFFFE. Each slot holds one or more request flags, and each flag has its own enable bit.

A slot is given a class when the block is built. The class decides how the flag enables and the global interrupt enable gate its flags:

- **Reset:** neither enable gates the flags.
- **Non-maskable:** neither enable gates the flags.
- **Partly maskable:** only the flag enables gate the flags.
- **Maskable:** both the flag enables and the global enable gate the flags.

The topmost slot is the reset slot. It is also raised when an instruction fetch targets the peripheral register range.

The chosen request is held on the outputs until the processor acknowledges it. A peripheral clears its own flag. After an acknowledge, the block drops its valid output for one cycle and then arbitrates again. A separate sticky output asks the system to enter its deepest sleep state. It is set when the reset vector word fetched after power-up reads as erased (all ones).

Top module: `irq_vector_ctrl`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `irq_valid_o`, `fetch_reset_o` and `sleep_o` are 0 after that edge, whatever the other inputs hold.
- R2: While `irq_valid_o` is 1, `vector_addr_o` equals 0x10000 − 2·NUM_SLOTS + 2·`priority_o`. With 32 slots, slot p maps to 0xFFC0 + 2p, so slot 31 maps to 0xFFFE and slot 0 maps to 0xFFC0.
- R3: When several slots are pending on the edge that captures a grant, the slot with the largest index is granted.
- R4: A maskable slot is pending only when some flag of the slot and its enable bit are both 1 and `gie_i` is 1. Flag j of slot s is bit s·FLAGS_PER_SLOT + j of `flag_i` and `flag_en_i`.
- R5: A partly maskable slot is pending when some flag and its enable are both 1, whatever `gie_i` holds. It is not pending when the enables of its set flags are 0.
- R6: A non-maskable slot is pending when any of its flags is 1, whatever the enables and `gie_i` hold.
- R7: The reset slot (slot NUM_SLOTS−1) is pending when any of its flags is 1, whatever the enables hold. Being the highest slot, it wins over every other slot.
- R8: A fetch with `fetch_valid_i`=1 and `fetch_addr_i` ≤ 0x01FF sets `fetch_reset_o` to 1 after the next edge and requests the reset slot on that same edge. A fetch at 0x0200 or above does neither.
- R9: `rv_valid_i`=1 with `rv_data_i`=0xFFFF sets `sleep_o` to 1 after the next edge. `sleep_o` then stays 1 until reset. Any other reset vector word leaves `sleep_o` at 0.
- R10: A slot that shares several flags is pending when any one of its enabled flags is set. Set flags whose enables are 0 do not make it pending.
- R11: While `irq_valid_o` is 1 and `irq_ack_i` is 0, `irq_valid_o`, `priority_o` and `vector_addr_o` keep their values, even when other requests change.
- R12: `irq_ack_i`=1 while `irq_valid_o` is 1 clears `irq_valid_o` after that edge. The next edge grants the best request pending then.
- R13: `irq_ack_i` is ignored while `irq_valid_o` is 0. A pending request is granted on that edge as if no acknowledge were present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_i | input | NUM_SLOTS·FLAGS_PER_SLOT | Request flags, grouped per slot |
| flag_en_i | input | NUM_SLOTS·FLAGS_PER_SLOT | Enable bit for each flag |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Acknowledge of the presented request |
| fetch_valid_i | input | 1 | An instruction fetch address is present |
| fetch_addr_i | input | 16 | Instruction fetch address |
| rv_valid_i | input | 1 | The reset vector word read is present |
| rv_data_i | input | 16 | Reset vector word read from 0xFFFE |
| irq_valid_o | output | 1 | A granted request is presented |
| vector_addr_o | output | 16 | Word address of the granted vector |
| priority_o | output | log2(NUM_SLOTS) | Index of the granted slot |
| fetch_reset_o | output | 1 | Fetch in the peripheral range seen on the last edge |
| sleep_o | output | 1 | Erased reset vector seen; enter deepest sleep |

## Verification
The bench builds the block with 32 slots and two flags per slot, so the full table from 0xFFC0 to 0xFFFE is used. Two flags per slot are enough to show that a shared slot is pending through either flag alone, and that a set flag with its enable at 0 does not count. The default class map gives the top three slots the reset, partly maskable and non-maskable classes, and makes every lower slot maskable. This lets each gating rule be tried against the global enable on its own slot. The bench also chains acknowledges so that lower slots are granted in turn once higher ones clear.

// File: rtl/irq_pkg.sv
// Shared types for the interrupt vector controller.
// Assumes: class codes are fixed at elaboration, two bits per slot.
package irq_pkg;

    // Gating class of one priority slot
    typedef enum logic [1:0] {
        CLS_MASKABLE = 2'd0,
        CLS_NMI      = 2'd1,
        CLS_PARTIAL  = 2'd2,
        CLS_RESET    = 2'd3
    } slot_class_e;

endpackage

// File: rtl/irq_slot_gate.sv
// Gates the flags of one priority slot by its class.
// Assumes: CLASS is constant; extra_i is an unmaskable request that is ORed in.
module irq_slot_gate
    import irq_pkg::*;
#(
    parameter int unsigned FLAGS = 4,
    parameter slot_class_e CLASS = CLS_MASKABLE
) (
    input  logic [FLAGS-1:0] flags_i,
    input  logic [FLAGS-1:0] en_i,
    input  logic             gie_i,
    input  logic             extra_i,
    output logic             pend_o
);

    logic any_raw;
    logic any_enabled;

    assign any_raw     = |flags_i;
    assign any_enabled = |(flags_i & en_i);

    // Select the gating rule named by the slot class
    always_comb begin
        unique case (CLASS)
            CLS_RESET:   pend_o = any_raw | extra_i;
            CLS_NMI:     pend_o = any_raw | extra_i;
            CLS_PARTIAL: pend_o = any_enabled | extra_i;
            default:     pend_o = (any_enabled & gie_i) | extra_i;
        endcase
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Finds the highest-index set bit of a request vector.
// Assumes: index 0 is the lowest priority; idx_o is 0 when nothing is set.
module irq_prio_pick #(
    parameter int unsigned N = 32,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan upward so the last (highest) set bit is kept
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
// Prioritized interrupt vector controller.
// Gates each slot by its class, grants the highest pending slot, and holds the
// grant until acknowledged. Flags fetches into the peripheral range as a reset
// request, and latches a sleep request when the reset vector reads as erased.
// Assumes: peripherals clear their own flags; the top slot carries the reset class.
module irq_vector_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS      = 32,
    parameter int unsigned FLAGS_PER_SLOT = 4,
    parameter logic [15:0] PERIPH_TOP     = 16'h01FF,
    parameter logic [2*NUM_SLOTS-1:0] SLOT_CLASS =
        {2'd3, 2'd2, 2'd1, {(2*NUM_SLOTS-6){1'b0}}},
    localparam int unsigned IDX_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int unsigned FLAG_W  = NUM_SLOTS * FLAGS_PER_SLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [FLAG_W-1:0] flag_en_i,
    input  logic              gie_i,
    input  logic              irq_ack_i,
    input  logic              fetch_valid_i,
    input  logic [15:0]       fetch_addr_i,
    input  logic              rv_valid_i,
    input  logic [15:0]       rv_data_i,
    output logic              irq_valid_o,
    output logic [15:0]       vector_addr_o,
    output logic [IDX_W-1:0]  priority_o,
    output logic              fetch_reset_o,
    output logic              sleep_o
);

    localparam logic [15:0] TABLE_BASE = 16'(32'h10000 - 2 * NUM_SLOTS);
    localparam logic [15:0] ERASED     = 16'hFFFF;

    logic [NUM_SLOTS-1:0] pend;
    logic                 any_pend;
    logic [IDX_W-1:0]     win_idx;
    logic                 fetch_hit;
    logic                 vld_q;
    logic [IDX_W-1:0]     pri_q;
    logic                 frst_q;
    logic                 sleep_q;

    // Detect a fetch into the peripheral register range
    assign fetch_hit = fetch_valid_i && (fetch_addr_i <= PERIPH_TOP);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        irq_slot_gate #(
            .FLAGS (FLAGS_PER_SLOT),
            .CLASS (slot_class_e'(SLOT_CLASS[2*s +: 2]))
        ) u_gate (
            .flags_i (flag_i[s*FLAGS_PER_SLOT +: FLAGS_PER_SLOT]),
            .en_i    (flag_en_i[s*FLAGS_PER_SLOT +: FLAGS_PER_SLOT]),
            .gie_i   (gie_i),
            .extra_i ((s == NUM_SLOTS - 1) ? fetch_hit : 1'b0),
            .pend_o  (pend[s])
        );
    end

    irq_prio_pick #(.N(NUM_SLOTS)) u_pick (
        .req_i (pend),
        .any_o (any_pend),
        .idx_o (win_idx)
    );

    // Grant register: capture when idle, hold until acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            pri_q <= '0;
        end else if (vld_q) begin
            if (irq_ack_i) vld_q <= 1'b0;
        end else if (any_pend) begin
            vld_q <= 1'b1;
            pri_q <= win_idx;
        end
    end

    // Fetch-range flag for one cycle after the offending fetch
    always_ff @(posedge clk) begin
        if (!rst_n) frst_q <= 1'b0;
        else        frst_q <= fetch_hit;
    end

    // Sticky sleep request on an erased reset vector
    always_ff @(posedge clk) begin
        if (!rst_n)                                 sleep_q <= 1'b0;
        else if (rv_valid_i && rv_data_i == ERASED) sleep_q <= 1'b1;
    end

    assign irq_valid_o   = vld_q;
    assign priority_o    = pri_q;
    assign vector_addr_o = TABLE_BASE + (16'(pri_q) << 1);
    assign fetch_reset_o = frst_q;
    assign sleep_o       = sleep_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Protocol checker for irq_vector_ctrl, bound to every instance.
// Assumes: rst_n is held low from time zero until the first clock edges.
module irq_vector_ctrl_chk #(
    parameter int unsigned NUM_SLOTS  = 32,
    parameter logic [15:0] PERIPH_TOP = 16'h01FF,
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack_i,
    input logic             fetch_valid_i,
    input logic [15:0]      fetch_addr_i,
    input logic             rv_valid_i,
    input logic [15:0]      rv_data_i,
    input logic             irq_valid_o,
    input logic [15:0]      vector_addr_o,
    input logic [IDX_W-1:0] priority_o,
    input logic             fetch_reset_o,
    input logic             sleep_o
);

    logic hit;
    assign hit = fetch_valid_i && (fetch_addr_i <= PERIPH_TOP);

    // R11
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o && !irq_ack_i |=> irq_valid_o && $stable(priority_o) && $stable(vector_addr_o));

    // R12
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o && irq_ack_i |=> !irq_valid_o);

    // R8
    fetch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> fetch_reset_o);

    // R8
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !fetch_reset_o);

    // R7
    reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o && hit |=> irq_valid_o && priority_o == IDX_W'(NUM_SLOTS - 1));

    // R9
    sleep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rv_valid_i && rv_data_i == 16'hFFFF |=> sleep_o);

    // R9
    sleep_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |=> sleep_o);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .PERIPH_TOP (PERIPH_TOP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_ack_i     (irq_ack_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .rv_valid_i    (rv_valid_i),
    .rv_data_i     (rv_data_i),
    .irq_valid_o   (irq_valid_o),
    .vector_addr_o (vector_addr_o),
    .priority_o    (priority_o),
    .fetch_reset_o (fetch_reset_o),
    .sleep_o       (sleep_o)
);

// File: tb/tb_irq_vector_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vector_ctrl;

    localparam int NS = 32;
    localparam int FP = 2;
    localparam int FW = NS * FP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] flag = '0;
    logic [FW-1:0] en = '0;
    logic          gie = 1'b0;
    logic          ack = 1'b0;
    logic          fv = 1'b0;
    logic [15:0]   fa = '0;
    logic          rvv = 1'b0;
    logic [15:0]   rvd = '0;
    logic          v_o;
    logic [15:0]   vec_o;
    logic [4:0]    pri_o;
    logic          fr_o;
    logic          sl_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        string tag;
        bit    v;
        int    p;
        bit    f;
        bit    s;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    irq_vector_ctrl #(.NUM_SLOTS(NS), .FLAGS_PER_SLOT(FP)) dut (
        .clk(clk), .rst_n(rst_n), .flag_i(flag), .flag_en_i(en), .gie_i(gie),
        .irq_ack_i(ack), .fetch_valid_i(fv), .fetch_addr_i(fa),
        .rv_valid_i(rvv), .rv_data_i(rvd), .irq_valid_o(v_o),
        .vector_addr_o(vec_o), .priority_o(pri_o), .fetch_reset_o(fr_o), .sleep_o(sl_o)
    );

    // Driver: one edge with the current inputs, then queue the expectation
    task automatic step(input string tag, input bit v, input int p, input bit f, input bit s);
        @(posedge clk);
        #1;
        exp_q.push_back('{tag, v, p, f, s});
        @(negedge clk);
    endtask

    task automatic set_flag(input int s, input int j, input bit fl, input bit e);
        flag[s*FP + j] = fl;
        en[s*FP + j]   = e;
    endtask

    task automatic clr_req();
        flag = '0;
        en   = '0;
    endtask

    // Monitor: compare outputs with the queued expectations away from the edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [15:0] ev;
            bit ok;
            e  = exp_q.pop_front();
            ev = 16'hFFC0 + 16'(2 * e.p);
            ok = (v_o == e.v) && (fr_o == e.f) && (sl_o == e.s);
            if (e.v) ok = ok && (int'(pri_o) == e.p) && (vec_o == ev);
            total++;
            if (!ok) begin
                bad++;
                $display("FAIL %s: actual v=%0b p=%0d vec=%h f=%0b s=%0b expected v=%0b p=%0d vec=%h f=%0b s=%0b",
                         e.tag, v_o, pri_o, vec_o, fr_o, sl_o, e.v, e.p, ev, e.f, e.s);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset clears outputs even with requests present
        set_flag(5, 0, 1, 1); gie = 1; rvv = 1; rvd = 16'hFFFF; fv = 1; fa = 16'h0010;
        step("R1 reset", 0, 0, 0, 0);
        step("R1 reset hold", 0, 0, 0, 0);
        clr_req(); gie = 0; rvv = 0; fv = 0; rst_n = 1;
        step("R1 idle", 0, 0, 0, 0);

        // R4: maskable needs enable and global enable
        set_flag(5, 0, 1, 1);
        step("R4 gie off", 0, 0, 0, 0);
        gie = 1;
        step("R4 R2 grant slot5", 1, 5, 0, 0);
        ack = 1; clr_req();
        step("R12 ack drops", 0, 0, 0, 0);
        ack = 0;
        step("R12 idle", 0, 0, 0, 0);
        set_flag(5, 0, 1, 0);
        step("R4 enable off", 0, 0, 0, 0);
        clr_req();

        // R10: shared slot flags
        set_flag(7, 0, 1, 0); set_flag(7, 1, 1, 0);
        step("R10 none enabled", 0, 0, 0, 0);
        set_flag(7, 1, 1, 1);
        step("R10 flag1 enabled", 1, 7, 0, 0);
        ack = 1; clr_req();
        step("R12 ack", 0, 0, 0, 0);
        ack = 0;
        step("R12 idle", 0, 0, 0, 0);

        // R5: partly maskable ignores global enable
        gie = 0; set_flag(30, 0, 1, 1);
        step("R5 gie off grant", 1, 30, 0, 0);
        ack = 1; clr_req();
        step("R12 ack", 0, 0, 0, 0);
        ack = 0; gie = 1; set_flag(30, 1, 1, 0);
        step("R5 enable off", 0, 0, 0, 0);
        clr_req();

        // R6: non-maskable ignores both enables
        gie = 0; set_flag(29, 0, 1, 0);
        step("R6 grant", 1, 29, 0, 0);
        ack = 1; clr_req();
        step("R12 ack", 0, 0, 0, 0);
        ack = 0; gie = 1;

        // R3: highest index wins, then lower ones in turn
        set_flag(3, 0, 1, 1); set_flag(12, 1, 1, 1); set_flag(20, 0, 1, 1);
        step("R3 pick 20", 1, 20, 0, 0);
        ack = 1; set_flag(20, 0, 0, 0);
        step("R12 ack 20", 0, 0, 0, 0);
        ack = 0;
        step("R12 R3 rearb 12", 1, 12, 0, 0);
        ack = 1; set_flag(12, 1, 0, 0);
        step("R12 ack 12", 0, 0, 0, 0);
        ack = 0;
        step("R3 rearb 3 R2 low", 1, 3, 0, 0);
        ack = 1; clr_req();
        step("R12 ack 3", 0, 0, 0, 0);
        ack = 0;

        // R11: grant held while a higher request appears
        set_flag(10, 0, 1, 1);
        step("R11 grant 10", 1, 10, 0, 0);
        set_flag(25, 1, 1, 1);
        step("R11 held 10", 1, 10, 0, 0);
        step("R11 still 10", 1, 10, 0, 0);
        ack = 1; set_flag(10, 0, 0, 0);
        step("R12 ack 10", 0, 0, 0, 0);
        ack = 0;
        step("R12 rearb 25", 1, 25, 0, 0);
        ack = 1; clr_req();
        step("R12 ack 25", 0, 0, 0, 0);

        // R13: ack while idle is ignored
        set_flag(8, 0, 1, 1);
        step("R13 ack idle grant", 1, 8, 0, 0);
        ack = 0;
        step("R13 held", 1, 8, 0, 0);
        ack = 1; clr_req();
        step("R12 ack 8", 0, 0, 0, 0);
        ack = 0;

        // R7: reset slot beats non-maskable, enables ignored
        gie = 0; set_flag(31, 1, 1, 0); set_flag(29, 0, 1, 0);
        step("R7 reset wins R2 top", 1, 31, 0, 0);
        ack = 1; clr_req();
        step("R12 ack 31", 0, 0, 0, 0);
        ack = 0; gie = 1;

        // R8: fetch range raises the reset slot
        fv = 1; fa = 16'h01FF;
        step("R8 fetch 01FF", 1, 31, 1, 0);
        fv = 0;
        step("R8 flag clears", 1, 31, 0, 0);
        ack = 1;
        step("R12 ack", 0, 0, 0, 0);
        ack = 0; fv = 1; fa = 16'h0200;
        step("R8 fetch 0200", 0, 0, 0, 0);
        fv = 0;

        // R9: erased reset vector
        rvv = 1; rvd = 16'h1234;
        step("R9 programmed", 0, 0, 0, 0);
        rvd = 16'hFFFF;
        step("R9 erased", 0, 0, 0, 1);
        rvv = 0; rvd = 16'h0000;
        step("R9 sticky", 0, 0, 0, 1);
        rst_n = 0;
        step("R1 reset clears sleep", 0, 0, 0, 0);
        rst_n = 1;
        step("R1 after reset", 0, 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule